// File: doc/BRIEF.md
# Priority Outbound Address Window Translator

This block sits on the local-bus side of a bus bridge and turns each 32-bit local address into a PCI address. It has three programmable windows. Windows 0 and 1 are general windows with a programmable size from 1 MB to 2 GB, their own PCI cycle type and an optional prefetch attribute. Window 2 is a fixed 16 MB window that always produces I/O cycles.

A request presents an address with a valid strobe. One cycle later the block returns a hit flag, the translated PCI address, the 3-bit cycle type and the prefetch attribute. Windows may overlap. The lowest-numbered enabled window that contains the address wins. Software relies on this to hide window 1 behind an enlarged window 0 while it points window 1 at configuration space, and then reveals it again.

A simple write port loads the six window registers. Each write takes effect for lookups in the cycle that follows it.

Top module: `outwin_xlat`

## Requirements
- R1: After synchronous reset every window is disabled and all response outputs are 0.
- R2: A general window register holds the local base in bits 31:20, a size code in bits 7:4, prefetch in bit 3 and enable in bit 0. Size code n spans (1 MB << n). Codes 12 to 15 behave like code 11 (2 GB). The window contains an address when the address bits above the span equal the base bits above the span.
- R3: For a general window, PCI address bits above the span come from map bits 15:4, which supply PCI bits 31:20. PCI address bits inside the span come from the local address.
- R4: Windows are tried in the order 0, 1, 2. The first enabled window that contains the address alone sets all the outputs, so a higher overlapping window is hidden.
- R5: For a general window, the cycle-type output is map bits 3:1 and the prefetch output is base bit 3. The type codes are 000 interrupt-acknowledge, 001 I/O, 011 memory, 101 configuration and 110 memory-multiple.
- R6: For a general window, map bit 0 = 0 forces PCI address bits 1:0 to 0, and map bit 0 = 1 passes local bits 1:0 through.
- R7: Window 2 is enabled by base bit 0. It hits when local bits 31:24 equal base bits 15:8. It replaces bits 31:24 with map bits 15:8, keeps local bits 23:0, and gives type 001 with prefetch 0.
- R8: When no window hits, or the request is not valid, the hit output is 0 and the address, type and prefetch outputs are 0.
- R9: The response appears on the clock edge after the request is sampled. The response valid output equals the request valid of the previous cycle.
- R10: The register select codes are 0 (base 0), 1 (map 0), 2 (base 1), 3 (map 1), 4 (base 2) and 5 (map 2). A lookup in the same cycle as a write uses the old contents. A window whose enable bit is 0 never hits.
- R11: When window 0 is enlarged to 512 MB over window 1's range, every address in that range translates through window 0, including while window 1 is being reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..5) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_cyc | output | 3 | PCI cycle type code |
| rsp_prefetch | output | 1 | Prefetchable attribute |

## Verification
Every response is due exactly one clock edge after its request is sampled. A register write affects only the lookups sampled on later edges. The bench drives a request and an optional write on a falling edge. It then compares all response outputs on the next falling edge against a behavioural model, which is evaluated with the register copy as it stood before that write. Since every cycle is checked at that one fixed offset, a response that is one cycle late, or a write that takes effect one cycle early, shows up as a mismatch in the cycle concerned.

// File: rtl/outwin_pkg.sv
package outwin_pkg;

    localparam int ADDR_W        = 32;
    localparam int MIN_SHIFT     = 20;
    localparam int MAX_SIZE_CODE = 11;
    localparam int IO_SHIFT      = 24;
    localparam int HI_W          = ADDR_W - MIN_SHIFT;
    localparam int IO_HI_W       = ADDR_W - IO_SHIFT;

    typedef logic [2:0] cyc_t;
    localparam cyc_t CYC_IACK = 3'b000;
    localparam cyc_t CYC_IO   = 3'b001;
    localparam cyc_t CYC_MEM  = 3'b011;
    localparam cyc_t CYC_CFG  = 3'b101;
    localparam cyc_t CYC_MEMM = 3'b110;

    typedef struct packed {
        logic [HI_W-1:0] base;
        logic [3:0]      size;
        logic            pf;
        logic            en;
        logic [HI_W-1:0] map;
        cyc_t            cyc;
        logic            adlow;
    } mem_win_t;

    typedef struct packed {
        logic [IO_HI_W-1:0] base;
        logic               en;
        logic [IO_HI_W-1:0] map;
    } io_win_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        cyc_t              cyc;
        logic              pf;
    } xlat_t;

    // Mask keeping only the address bits above the window span.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [3:0] code);
        logic [3:0] n;
        n = (code > 4'(MAX_SIZE_CODE)) ? 4'(MAX_SIZE_CODE) : code;
        return ~((ADDR_W'(1) << (MIN_SHIFT + int'(n))) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/outwin_regs.sv
module outwin_regs
    import outwin_pkg::*;
#(
    parameter int N_MEM_WIN = 2,
    localparam int SEL_W = $clog2(2 * N_MEM_WIN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] wdata,
    output mem_win_t          win_q [N_MEM_WIN],
    output io_win_t           io_q
);
    localparam logic [SEL_W-1:0] SEL_IO_BASE = SEL_W'(2 * N_MEM_WIN);
    localparam logic [SEL_W-1:0] SEL_IO_MAP  = SEL_W'(2 * N_MEM_WIN + 1);

    logic cfg_unused;
    assign cfg_unused = ^wdata[MIN_SHIFT-1:16];

    for (genvar w = 0; w < N_MEM_WIN; w++) begin : g_mem
        localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(2 * w);
        localparam logic [SEL_W-1:0] SEL_MAP  = SEL_W'(2 * w + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[w] <= '0;
            end else if (we && sel == SEL_BASE) begin
                win_q[w].base <= wdata[ADDR_W-1:MIN_SHIFT];
                win_q[w].size <= wdata[7:4];
                win_q[w].pf   <= wdata[3];
                win_q[w].en   <= wdata[0];
            end else if (we && sel == SEL_MAP) begin
                win_q[w].map   <= wdata[15:4];
                win_q[w].cyc   <= wdata[3:1];
                win_q[w].adlow <= wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q <= '0;
        end else if (we && sel == SEL_IO_BASE) begin
            io_q.base <= wdata[15:8];
            io_q.en   <= wdata[0];
        end else if (we && sel == SEL_IO_MAP) begin
            io_q.map <= wdata[15:8];
        end
    end

endmodule

// File: rtl/outwin_mem_match.sv
module outwin_mem_match
    import outwin_pkg::*;
(
    input  mem_win_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output xlat_t             res
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] map_full;
    logic [ADDR_W-1:0] pci;

    always_comb begin
        mask      = span_mask(cfg.size);
        base_full = {cfg.base, {MIN_SHIFT{1'b0}}};
        map_full  = {cfg.map, {MIN_SHIFT{1'b0}}};
        pci       = (map_full & mask) | (addr & ~mask);
        if (!cfg.adlow) pci[1:0] = 2'b00;
        res.hit  = cfg.en && ((addr & mask) == (base_full & mask));
        res.addr = pci;
        res.cyc  = cfg.cyc;
        res.pf   = cfg.pf;
    end

endmodule

// File: rtl/outwin_io_match.sv
module outwin_io_match
    import outwin_pkg::*;
(
    input  io_win_t           cfg,
    input  logic [ADDR_W-1:0] addr,
    output xlat_t             res
);
    always_comb begin
        res.hit  = cfg.en && (addr[ADDR_W-1:IO_SHIFT] == cfg.base);
        res.addr = {cfg.map, addr[IO_SHIFT-1:0]};
        res.cyc  = CYC_IO;
        res.pf   = 1'b0;
    end

endmodule

// File: rtl/outwin_pick.sv
module outwin_pick
    import outwin_pkg::*;
#(
    parameter int N_CAND = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  xlat_t cand [N_CAND],
    output logic  valid_q,
    output xlat_t res_q
);
    xlat_t win;

    // Scan from the top so the lowest-numbered hit is written last.
    always_comb begin
        win = '0;
        for (int i = N_CAND - 1; i >= 0; i--) begin
            if (cand[i].hit) win = cand[i];
        end
        if (!valid) win = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            res_q   <= win;
            valid_q <= valid;
        end
    end

endmodule

// File: rtl/outwin_xlat.sv
module outwin_xlat
    import outwin_pkg::*;
#(
    parameter int N_MEM_WIN = 2,
    localparam int SEL_W  = $clog2(2 * N_MEM_WIN + 2),
    localparam int N_CAND = N_MEM_WIN + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [2:0]        rsp_cyc,
    output logic              rsp_prefetch
);
    mem_win_t win_q [N_MEM_WIN];
    io_win_t  io_q;
    xlat_t    cand  [N_CAND];
    xlat_t    res_q;

    outwin_regs #(.N_MEM_WIN(N_MEM_WIN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .win_q (win_q),
        .io_q  (io_q)
    );

    for (genvar w = 0; w < N_MEM_WIN; w++) begin : g_match
        outwin_mem_match u_mem (
            .cfg  (win_q[w]),
            .addr (req_addr),
            .res  (cand[w])
        );
    end

    outwin_io_match u_io (
        .cfg  (io_q),
        .addr (req_addr),
        .res  (cand[N_MEM_WIN])
    );

    outwin_pick #(.N_CAND(N_CAND)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .valid   (req_valid),
        .cand    (cand),
        .valid_q (rsp_valid),
        .res_q   (res_q)
    );

    assign rsp_hit      = res_q.hit;
    assign rsp_addr     = res_q.addr;
    assign rsp_cyc      = res_q.cyc;
    assign rsp_prefetch = res_q.pf;

endmodule

// File: rtl/outwin_checker.sv
module outwin_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_addr,
    input logic [2:0]  rsp_cyc,
    input logic        rsp_prefetch,
    input logic        first_hit,
    input logic [2:0]  first_cyc,
    input logic        first_adlow
);
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_addr == 32'd0 && rsp_cyc == 3'd0 && !rsp_prefetch));

    assert_idle_nohit_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_hit);

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    assert_offset_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_hit) |-> (rsp_addr[19:2] == $past(req_addr[19:2])));

    assert_first_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && first_hit) |=> (rsp_hit && rsp_cyc == $past(first_cyc)));

    assert_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && first_hit && !first_adlow) |=> (rsp_addr[1:0] == 2'b00));

endmodule

bind outwin_xlat outwin_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_addr     (rsp_addr),
    .rsp_cyc      (rsp_cyc),
    .rsp_prefetch (rsp_prefetch),
    .first_hit    (cand[0].hit),
    .first_cyc    (cand[0].cyc),
    .first_adlow  (win_q[0].adlow)
);

// File: tb/outwin_xlat_bench.sv
module outwin_xlat_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_prefetch;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_cyc;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench copy of the register contents
    logic [31:0] mb [2];
    logic [15:0] mm [2];
    logic [15:0] iob, iom;

    logic [37:0] exp_pack;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    outwin_xlat u_outwin_xlat (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .rsp_cyc(rsp_cyc), .rsp_prefetch(rsp_prefetch)
    );

    function automatic logic [37:0] model(input bit v, input logic [31:0] a);
        bit h = 0;
        logic [31:0] pa = '0;
        logic [2:0] c = '0;
        bit pf = 0;
        longint unsigned a64 = a;
        for (int w = 0; w < 2; w++) begin
            int n;
            longint unsigned span, lo, mp;
            n = int'(mb[w][7:4]);
            if (n > 11) n = 11;
            span = 64'd1 << (20 + n);
            lo = longint'({mb[w][31:20], 20'h0}) & ~(span - 1);
            mp = longint'({mm[w][15:4], 20'h0}) & ~(span - 1);
            if (!h && mb[w][0] && a64 >= lo && a64 < lo + span) begin
                h  = 1;
                pa = 32'(mp + (a64 - lo));
                if (!mm[w][0]) pa[1:0] = 2'b00;
                c  = mm[w][3:1];
                pf = mb[w][3];
            end
        end
        if (!h && iob[0] && a[31:24] == iob[15:8]) begin
            h = 1;
            pa = {iom[15:8], a[23:0]};
            c = 3'b001;
            pf = 0;
        end
        if (!v || !h) return {v, 37'd0};
        return {v, h, c, pf, pa};
    endfunction

    task automatic check_now();
        logic [37:0] act;
        act = {rsp_valid, rsp_hit, rsp_cyc, rsp_prefetch, rsp_addr};
        total++;
        if (act !== exp_pack) begin
            bad++;
            $display("FAIL %s: actual v=%0b hit=%0b cyc=%0d pf=%0b addr=%08h expected v=%0b hit=%0b cyc=%0d pf=%0b addr=%08h",
                exp_tag, act[37], act[36], act[35:33], act[32], act[31:0],
                exp_pack[37], exp_pack[36], exp_pack[35:33], exp_pack[32], exp_pack[31:0]);
        end
    endtask

    // Called on a falling edge: check last cycle, drive this cycle.
    task automatic step(input bit we, input int sel, input logic [31:0] d,
                        input bit v, input logic [31:0] a, input string tag);
        check_now();
        cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = d;
        req_valid = v; req_addr = a;
        exp_pack = model(v, a);
        exp_tag = tag;
        if (we) begin
            case (sel)
                0: mb[0] = d;
                1: mm[0] = d[15:0];
                2: mb[1] = d;
                3: mm[1] = d[15:0];
                4: iob = d[15:0];
                5: iom = d[15:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input logic [31:0] d, input string tag);
        step(1, sel, d, 0, 32'd0, tag);
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        step(0, 0, 32'd0, 1, a, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 2; w++) begin mb[w] = '0; mm[w] = '0; end
        iob = '0; iom = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_pack = '0; exp_tag = "R1";
        check_now();                               // R1 reset outputs
        look(32'h4000_0000, "R1");                 // R1 nothing enabled
        // window 0: 256 MB at 0x4000_0000 -> 0x8000_0000, memory, low bits zeroed
        wr(0, 32'h4000_0081, "R10");
        wr(1, 32'h0000_8006, "R10");
        look(32'h4123_4567, "R3");                 // R3 R6 -> 8123_4564
        look(32'h4FFF_FFFF, "R2");                 // R2 upper edge
        look(32'h5000_0000, "R8");                 // R8 just past window
        // window 1: 256 MB at 0x5000_0000 prefetch -> 0x9000_0000, low bits pass
        wr(2, 32'h5000_0089, "R10");
        wr(3, 32'h0000_9007, "R10");
        look(32'h5ABC_DEF3, "R5");                 // R5 R6 pf=1
        look(32'h3FFF_FFFF, "R8");
        step(0, 0, 32'd0, 0, 32'h4123_4567, "R8"); // R8 R9 not valid
        // window 2: I/O at 0x60xx_xxxx -> 0x12xx_xxxx
        wr(4, 32'h0000_6001, "R10");
        wr(5, 32'h0000_1200, "R10");
        look(32'h6012_3457, "R7");
        look(32'h6112_0000, "R7");                 // R7 miss outside
        // enlarge window 0 to 512 MB, occluding window 1
        wr(0, 32'h4000_0091, "R11");
        look(32'h5000_0013, "R11");                // via window 0
        wr(2, 32'h5000_0041, "R11");               // window 1 -> 16 MB config
        wr(3, 32'h0000_000B, "R11");
        look(32'h5000_0123, "R11");                // still window 0
        // shrink window 0 while looking up in the same cycle
        step(1, 0, 32'h4000_0081, 1, 32'h5000_0123, "R10");
        look(32'h5000_0123, "R4");                 // now window 1 config
        look(32'h5100_0000, "R2");                 // outside 16 MB
        // size sweep on window 0
        wr(0, 32'h4010_0001, "R2");                // 1 MB
        look(32'h4010_0005, "R2");
        look(32'h4020_0000, "R2");
        wr(0, 32'h8000_00B1, "R2");                // 2 GB
        look(32'hF000_0002, "R2");
        wr(0, 32'h0000_00F9, "R2");                // code 15 acts as 2 GB at 0
        look(32'h6012_3457, "R4");                 // window 0 over I/O
        look(32'h7FFF_FFFF, "R2");
        look(32'h8000_0000, "R2");
        // cycle-type codes through window 0
        wr(1, 32'h0000_A000, "R5");                // iack, low zero
        look(32'h1234_5677, "R5");
        wr(1, 32'h0000_A00D, "R5");                // memory-multiple, low pass
        look(32'h1234_5677, "R6");
        // disable
        wr(0, 32'h0000_00F8, "R10");
        look(32'h1234_5677, "R10");
        wr(4, 32'h0000_6000, "R10");
        look(32'h6012_3457, "R10");
        step(0, 0, 32'd0, 0, 32'd0, "R9");
        check_now();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule